// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block sits beside a 32-bit multiplexed address/data bus that has four active-low command/byte-enable lines. It computes the even-parity bit for every bus clock. When the local agent is the one driving AD, it drives that bit back onto the bus one clock later. When another agent drives AD, it compares the parity that agent sends one clock later against its own computation.

Errors are reported in two ways. A mismatch on a completed data transfer that this agent has claimed pulls the data-parity-error line low. That line is then driven high for one clock and released, as a sustained tri-state signal. A mismatch on an address phase, or on data of a special-cycle broadcast, raises a single-clock pull-down enable on the open-drain system-error line instead. The block owns no configuration state. The host decides when `drv_ad` and `claim` are true, and the block turns the bus handshakes into parity and error timing.

Top module: `bus_parity_engine`

## Requirements
- R1: Whenever `par_oe` is high, the count of ones across the AD bits and C/BE lines sampled on the previous clock, plus `par_out`, is even.
- R2: `par_out` and `par_oe` in cycle c+1 reflect the AD/C/BE values and `drv_ad` of cycle c. `par_oe` is low in cycle c+1 when `drv_ad` was low in cycle c.
- R3: An address phase is a cycle in which `frame_n` is low and, in the previous cycle, `frame_n` and `irdy_n` were both high (the first cycle after reset counts as idle). The command is taken from `cbe_n_in` in that cycle.
- R4: An address phase received with `drv_ad` low, whose `par_in` in the next cycle mismatches, raises `serr_pd` in the cycle two clocks after the address phase. It never drives the data-parity-error line.
- R5: A data completion in cycle c (`irdy_n` and `trdy_n` both low, not an address phase) is checked when all of these hold: `drv_ad` is low, `claim` is high, `devsel_n` is low, and the command is not special. If `par_in` in cycle c+1 mismatches, then `perr_oe` is high and `perr_n_out` is low in cycle c+2.
- R6: After the last cycle with `perr_n_out` low, the line is driven high (`perr_oe` high) for exactly one cycle and then released (`perr_oe` low). Errors on back-to-back completions keep it low.
- R7: No data-parity error is reported for a clock without a completion (a wait state), for a clock with `drv_ad` high, or for a clock with `claim` low or `devsel_n` high.
- R8: With the special-cycle command (`cbe_n_in` = 4'b0001 in the address phase), a data mismatch under the conditions of R5, minus the `claim`/`devsel_n` condition, raises `serr_pd` two clocks after the completion and never the data-parity-error line.
- R9: `serr_pd` is never high in two consecutive cycles. The system-error line is only ever pulled down.
- R10: While reset is asserted, `par_oe`, `perr_oe` and `serr_pd` are low and `par_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Address/data value seen on the bus |
| cbe_n_in | input | 4 | Command / byte-enable lines as seen on the bus |
| par_in | input | 1 | Parity bit seen on the bus |
| frame_n | input | 1 | Transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| drv_ad | input | 1 | Local agent drives AD in this cycle |
| claim | input | 1 | Local agent takes part in the current access |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Output enable for `par_out` |
| perr_n_out | output | 1 | Data-parity-error level to drive |
| perr_oe | output | 1 | Output enable for the data-parity-error line |
| serr_pd | output | 1 | Pull-down enable for the system-error line |

## Verification
A wrong phase tracker shows up as a system-error pulse that is missing or misplaced, exactly two clocks after a corrupted address, so single-bit flips on every AD and C/BE lane are swept across address and data phases. A stuck or mis-timed qualifier flag shows within two clocks of the completion as a data-parity-error pulse with the wrong presence. A broken release sequencer shows on the cycle after the last low pulse. The sweep repeats with the claim and device-select inputs on and off, and a long random run compares every output every cycle against an arithmetic model.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_SPECIAL = 4'b0001;

  // check qualifiers captured in the cycle that carries the data
  typedef struct packed {
    logic addr_chk;
    logic data_perr;
    logic data_serr;
  } chk_flags_t;

  function automatic logic is_special(input logic [CMD_W-1:0] cmd);
    return cmd == CMD_SPECIAL;
  endfunction
endpackage

// File: rtl/bpe_phase_track.sv
module bpe_phase_track
  import bpe_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic [BE_W-1:0] cbe_n,
  output logic            addr_ph,
  output logic            xfer,
  output logic            cmd_special
);
  logic            idle_q;
  logic [BE_W-1:0] cmd_q;

  assign addr_ph     = !frame_n && idle_q;
  assign xfer        = !irdy_n && !trdy_n && !addr_ph;
  assign cmd_special = is_special(CMD_W'(cmd_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      cmd_q  <= '0;
    end else begin
      idle_q <= frame_n && irdy_n;
      if (addr_ph) cmd_q <= cbe_n;
    end
  end

  AST_ADDR_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |=> !addr_ph); // R3
endmodule

// File: rtl/bpe_par_gen.sv
module bpe_par_gen #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            drv_ad,
  output logic            par_out,
  output logic            par_oe
);
  localparam int LANE_W = AD_W / BE_W;

  logic [BE_W-1:0] lane_par;
  logic            par_calc;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_par[g] = ^{ad[g*LANE_W +: LANE_W], cbe_n[g]};
  end

  assign par_calc = ^lane_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= 1'b0;
      par_oe  <= 1'b0;
    end else begin
      par_out <= par_calc;
      par_oe  <= drv_ad;
    end
  end

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (($countones({$past(ad), $past(cbe_n), par_out}) % 2) == 0)); // R1
  AST_PAR_OE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    drv_ad |=> par_oe); // R2
endmodule

// File: rtl/bpe_err_report.sv
module bpe_err_report
  import bpe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic par_in,
  input  logic par_ref,
  input  logic addr_ph,
  input  logic xfer,
  input  logic cmd_special,
  input  logic drv_ad,
  input  logic claim,
  input  logic devsel_n,
  output logic perr_n_out,
  output logic perr_oe,
  output logic serr_pd
);
  chk_flags_t flags_d, flags_q;
  logic par_mismatch;
  logic dperr_hit;
  logic serr_hit;
  logic perr_low_q, perr_hi_q, serr_q;

  always_comb begin
    flags_d.addr_chk  = addr_ph && !drv_ad;
    flags_d.data_serr = xfer && !drv_ad && cmd_special;
    flags_d.data_perr = xfer && !drv_ad && !cmd_special && claim && !devsel_n;
  end

  assign par_mismatch = par_in ^ par_ref;
  assign dperr_hit    = flags_q.data_perr && par_mismatch;
  assign serr_hit     = (flags_q.addr_chk || flags_q.data_serr) && par_mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q    <= '0;
      perr_low_q <= 1'b0;
      perr_hi_q  <= 1'b0;
      serr_q     <= 1'b0;
    end else begin
      flags_q    <= flags_d;
      perr_low_q <= dperr_hit;
      perr_hi_q  <= perr_low_q && !dperr_hit;
      serr_q     <= serr_hit && !serr_q;
    end
  end

  assign perr_n_out = !perr_low_q;
  assign perr_oe    = perr_low_q || perr_hi_q;
  assign serr_pd    = serr_q;

  AST_PERR_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |=> perr_oe); // R6
  AST_PERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_n_out) |=> (!perr_oe || !perr_n_out)); // R6
  AST_SERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pd |=> !serr_pd); // R9
  AST_SERR_EXCLUDES_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pd |-> !(perr_oe && !perr_n_out)); // R8
  AST_PERR_FROM_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |-> $past(flags_q.data_perr)); // R5
endmodule

// File: rtl/bus_parity_engine.sv
module bus_parity_engine #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_in,
  input  logic [BE_W-1:0] cbe_n_in,
  input  logic            par_in,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            devsel_n,
  input  logic            drv_ad,
  input  logic            claim,
  output logic            par_out,
  output logic            par_oe,
  output logic            perr_n_out,
  output logic            perr_oe,
  output logic            serr_pd
);
  logic addr_ph;
  logic xfer;
  logic cmd_special;

  bpe_phase_track #(.BE_W(BE_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .trdy_n      (trdy_n),
    .cbe_n       (cbe_n_in),
    .addr_ph     (addr_ph),
    .xfer        (xfer),
    .cmd_special (cmd_special)
  );

  bpe_par_gen #(.AD_W(AD_W), .BE_W(BE_W)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .ad      (ad_in),
    .cbe_n   (cbe_n_in),
    .drv_ad  (drv_ad),
    .par_out (par_out),
    .par_oe  (par_oe)
  );

  bpe_err_report u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .par_in      (par_in),
    .par_ref     (par_out),
    .addr_ph     (addr_ph),
    .xfer        (xfer),
    .cmd_special (cmd_special),
    .drv_ad      (drv_ad),
    .claim       (claim),
    .devsel_n    (devsel_n),
    .perr_n_out  (perr_n_out),
    .perr_oe     (perr_oe),
    .serr_pd     (serr_pd)
  );

  AST_PERR_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |-> ($past(claim, 2) && !$past(devsel_n, 2))); // R7
  AST_PERR_NOT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |-> !$past(drv_ad, 2)); // R7
endmodule

// File: tb/bus_parity_engine_tb.sv
module bus_parity_engine_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n_in = 4'hF;
  logic        par_in = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1;
  logic        drv_ad = 1'b0, claim = 1'b0;
  logic        par_out, par_oe, perr_n_out, perr_oe, serr_pd;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_par, m_paroe, m_ac, m_dp, m_ds, m_plow, m_phi, m_serr, m_idle;
  bit [3:0] m_cmd;
  bit pend_par;

  always #(CLK_P/2) clk = ~clk;

  bus_parity_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n_in(cbe_n_in), .par_in(par_in),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .drv_ad(drv_ad), .claim(claim), .par_out(par_out), .par_oe(par_oe),
    .perr_n_out(perr_n_out), .perr_oe(perr_oe), .serr_pd(serr_pd)
  );

  function automatic bit fill_bit(input logic [31:0] a, input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    for (int i = 0; i < 4; i++) n += int'(c[i]);
    return (n % 2) == 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_par = 0; m_paroe = 0; m_ac = 0; m_dp = 0; m_ds = 0;
    m_plow = 0; m_phi = 0; m_serr = 0; m_idle = 1; m_cmd = '0; pend_par = 0;
  endtask

  task automatic compare();
    chk(par_oe == m_paroe, "R2 par_oe", int'(par_oe), int'(m_paroe));
    if (m_paroe) chk(par_out == m_par, "R1 par_out", int'(par_out), int'(m_par));
    chk(perr_oe == (m_plow || m_phi), "R5 R6 R7 perr_oe", int'(perr_oe), int'(m_plow || m_phi));
    if (m_plow || m_phi)
      chk(perr_n_out == !m_plow, "R5 R6 perr_n_out", int'(perr_n_out), int'(!m_plow));
    chk(serr_pd == m_serr, "R3 R4 R8 R9 serr_pd", int'(serr_pd), int'(m_serr));
  endtask

  // one bus clock; flip picks an AD (0..31) or C/BE (32..35) bit to corrupt, fpar corrupts the parity sent next
  task automatic cyc(input bit fr, input bit ir, input bit tr, input bit dv, input bit drv,
                     input bit clm, input logic [31:0] a, input logic [3:0] c,
                     input int flip, input bit fpar);
    logic [31:0] da;
    logic [3:0]  dc;
    bit bad, n_plow, n_phi, n_serr, addr, xf, n_ac, n_dp, n_ds;
    da = a; dc = c;
    if (flip >= 0 && flip < 32) da[flip] = ~da[flip];
    else if (flip >= 32 && flip < 36) dc[flip-32] = ~dc[flip-32];
    frame_n = fr; irdy_n = ir; trdy_n = tr; devsel_n = dv; drv_ad = drv; claim = clm;
    ad_in = da; cbe_n_in = dc; par_in = pend_par;
    @(posedge clk);
    bad    = (pend_par != m_par);
    n_plow = m_dp && bad;
    n_phi  = m_plow && !n_plow;
    n_serr = (m_ac || m_ds) && bad && !m_serr;
    addr   = !fr && m_idle;
    xf     = !ir && !tr && !addr;
    n_ac   = addr && !drv;
    n_ds   = xf && !drv && (m_cmd == 4'b0001);
    n_dp   = xf && !drv && (m_cmd != 4'b0001) && clm && !dv;
    if (addr) m_cmd = dc;
    m_idle = fr && ir;
    m_par = fill_bit(da, dc); m_paroe = drv;
    m_ac = n_ac; m_dp = n_dp; m_ds = n_ds;
    m_plow = n_plow; m_phi = n_phi; m_serr = n_serr;
    pend_par = fill_bit(a, c) ^ fpar;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 0, 0, 32'h0, 4'hF, -1, 0);
  endtask

  // received write burst: address, completion, wait state, last completion
  task automatic rx_txn(input bit clm, input bit dsel, input logic [3:0] cmd,
                        input int ph, input int b, input logic [31:0] base);
    int fl0, fl1, fl2;
    bit fp0, fp1, fp2;
    bit dv;
    dv = !dsel;
    fl0 = (ph == 0 && b < 36) ? b : -1; fp0 = (ph == 0 && b == 36);
    fl1 = (ph == 1 && b < 36) ? b : -1; fp1 = (ph == 1 && b == 36);
    fl2 = (ph == 2 && b < 36) ? b : -1; fp2 = (ph == 2 && b == 36);
    cyc(0, 1, 1, 1, 0, clm, base, cmd, fl0, fp0);
    cyc(0, 0, 0, dv, 0, clm, ~base, 4'h0, fl1, fp1);
    cyc(1, 0, 1, dv, 0, clm, base ^ 32'h5A5A_0F0F, 4'h3, -1, 0);
    cyc(1, 0, 0, dv, 0, clm, base ^ 32'h5A5A_0F0F, 4'h3, fl2, fp2);
    idle(3);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    // R10: outputs while reset is held
    chk(par_oe == 0, "R10 par_oe in reset", int'(par_oe), 0);
    chk(perr_oe == 0, "R10 perr_oe in reset", int'(perr_oe), 0);
    chk(serr_pd == 0, "R10 serr_pd in reset", int'(serr_pd), 0);
    chk(par_out == 0, "R10 par_out in reset", int'(par_out), 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2: driving agent, walking ones over AD and C/BE
    for (int i = 0; i < 36; i++) begin
      logic [31:0] a;
      logic [3:0]  c;
      a = (i < 32) ? (32'h1 << i) : 32'h8000_0001;
      c = (i >= 32) ? (4'h1 << (i - 32)) : 4'h0;
      cyc(i == 0 ? 0 : 1, 1, 1, 1, 1, 1, a, c, -1, 0);
    end
    idle(2);

    // R3 R4 R5 R7 R8: single-bit flips over every lane, phase, claim and devsel setting
    for (int clm = 0; clm < 2; clm++)
      for (int ds = 0; ds < 2; ds++)
        for (int k = 0; k < 2; k++)
          for (int ph = 0; ph < 3; ph++)
            for (int b = 0; b < 38; b++)
              rx_txn(clm[0], ds[0], k == 0 ? 4'b0111 : 4'b0001, ph, b,
                     32'h1234_0000 + 32'(b * 77 + ph));

    // R6: back-to-back corrupted completions keep PERR low, then one high cycle
    cyc(0, 1, 1, 1, 0, 1, 32'hCAFE_0000, 4'b0111, -1, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'h1111_1111, 4'h0, 3, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'h2222_2222, 4'h0, 7, 0);
    cyc(1, 0, 0, 0, 0, 1, 32'h3333_3333, 4'h0, -1, 1);
    idle(4);

    // R9: special cycle with consecutive corrupted completions
    cyc(0, 1, 1, 1, 0, 0, 32'hBEEF_0000, 4'b0001, -1, 0);
    cyc(0, 0, 0, 1, 0, 0, 32'h0F0F_0F0F, 4'h0, 1, 0);
    cyc(0, 0, 0, 1, 0, 0, 32'hF0F0_F0F0, 4'h0, 2, 0);
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_FFFF, 4'h0, 33, 0);
    idle(4);

    // R7 R2: read data driven locally is never checked
    cyc(0, 1, 1, 1, 0, 1, 32'hA000_0000, 4'b0110, -1, 0);
    cyc(0, 0, 0, 0, 1, 1, 32'h1357_9BDF, 4'h0, -1, 1);
    cyc(1, 0, 0, 0, 1, 1, 32'h2468_ACE0, 4'h0, -1, 1);
    idle(4);

    // random traffic compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom);
      cyc(r[0] | r[1], r[2] & r[3], r[4], r[5] & r[6], r[7] & r[8], r[9] | r[10],
          $urandom, 4'(r[14:11]), (r[15] & r[16]) ? int'(r[22:17]) : -1, r[23] & r[24]);
    end

    // R10: reset in the middle of traffic clears everything
    cyc(0, 1, 1, 1, 0, 1, 32'h7777_0000, 4'b0111, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 32'h1, 4'h0, -1, 0);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(par_oe == 0, "R10 par_oe after reset", int'(par_oe), 0);
    chk(perr_oe == 0, "R10 perr_oe after reset", int'(perr_oe), 0);
    chk(serr_pd == 0, "R10 serr_pd after reset", int'(serr_pd), 0);
    chk(par_out == 0, "R10 par_out after reset", int'(par_out), 0);
    model_reset();
    rst_n = 1'b1;
    idle(3);
    rx_txn(1, 1, 4'b0111, 1, 36, 32'h4242_4242);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule